// File: doc/BRIEF.md
# Transfer Address Sequencer

This block keeps the source and destination addresses of a simple data-transfer engine and moves them forward, backward or not at all each time the engine reports that one data unit has been moved. A 16-bit control word sets the policy of each address, the data unit size and the transfer mode. The unit size scales every address step to 1, 2 or 4. Software-side logic programs the base addresses, a transfer count and a block configuration through a small write port. A start pulse then copies the bases into the live address registers and arms the counters.

Three modes share one address datapath. Normal mode counts transfers down and raises `done` at zero. Repeat mode runs without end: every count-th transfer returns both addresses to their bases and reloads the count. Block mode moves a programmed number of units per block. At the end of each block it returns one chosen side to its base and counts the block. An illegal size or mode code raises `cfg_err` and freezes the addresses until a legal control word is written.

Top module: `dma_addr_update`

## Requirements
- R1: After reset, `src_addr`, `dst_addr`, `size_code`, `cfg_err` and `done` are all zero.
- R2: Writes select a register through `wr_sel`: 0 control word (`wr_data[15:0]`), 1 source base, 2 destination base, 3 transfer count (`wr_data[15:0]`), 4 block configuration. A base write alone leaves the live addresses unchanged. A `start` pulse loads both live addresses from the bases and clears `done`, visible the cycle after the pulse.
- R3: Control bits 15:14 set the source policy: 00 or 01 fixed, 10 add one step, 11 subtract one step. The step is applied in the cycle after each accepted `xfer_done` strobe.
- R4: Control bits 13:12 set the destination policy with the same codes as R3, independently of the source.
- R5: Control bits 9:8 set the unit size: 00 step 1, 01 step 2, 10 step 4. `size_code` shows these two bits.
- R6: Address arithmetic wraps modulo 2^32 in both directions.
- R7: A control word with bits 9:8 = 11 or bits 11:10 = 11 sets `cfg_err` in the next cycle. While `cfg_err` is set, `xfer_done` changes no address and no counter. A later legal control word clears `cfg_err`.
- R8: Normal mode (bits 11:10 = 00): each transfer decrements the count. The transfer that brings it to zero sets `done`. After that, strobes are ignored until the next `start`.
- R9: Repeat mode (bits 11:10 = 01): on every count-th transfer, both addresses return to their bases and the count reloads. `done` stays low.
- R10: Block mode (bits 11:10 = 10): the block configuration gives the units per block in bits 15:0 and the restored side in bit 16 (0 source, 1 destination). On the last unit of each block, that side returns to its base while the other side steps. The count then drops by one block, and the last block sets `done`.
- R11: A `start` with a zero count, or with a zero block length in block mode, sets `done` at once, and no strobe moves an address.
- R12: `xfer_done` before any `start` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| start | input | 1 | Load addresses and counters from programmed values |
| xfer_done | input | 1 | One data unit has been moved |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| size_code | output | 2 | Unit size field of the control word |
| cfg_err | output | 1 | Prohibited size or mode code loaded |
| done | output | 1 | Transfer sequence finished |

## Verification
The bench uses the default parameters: 32-bit addresses and a 16-bit count. Because the address width is the full 32 bits, bases set just below 2^32 and just above zero make both wrap directions reachable in a few strobes. The small counts and block lengths bring every repeat reload and every block boundary, on both restored sides, within a few dozen cycles. Back-to-back strobes and strobes arriving after `done` are compared against the behavioural model on every clock.

// File: rtl/dma_au_pkg.sv
package dma_au_pkg;

  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_BAD    = 2'b11
  } xmode_e;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_SRC  = 3'd1,
    SEL_DST  = 3'd2,
    SEL_CNT  = 3'd3,
    SEL_BLK  = 3'd4
  } wsel_e;

  // Prohibited encodings: transfer mode 11 or unit size 11.
  function automatic logic ctrl_illegal(input logic [15:0] c);
    return (c[11:10] == 2'b11) || (c[9:8] == 2'b11);
  endfunction

endpackage

// File: rtl/dma_au_chan.sv
module dma_au_chan #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          reload,
  input  logic          adv,
  input  logic [1:0]    pol,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] step;
  assign step = ONE << size;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load || reload) begin
      addr <= base;
    end else if (adv && pol[1]) begin
      addr <= pol[0] ? (addr - step) : (addr + step);
    end
  end

  // R3/R4: a fixed policy never moves the address
  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !reload && !pol[1]) |=> $stable(addr));

  // R5/R6: increment uses the size-scaled step, modulo 2^AW
  p_inc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && pol == 2'b10 && !load && !reload && size != 2'b11)
    |=> addr == $past(addr) + (ONE << $past(size)));

  p_dec_step_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && pol == 2'b11 && !load && !reload && size != 2'b11)
    |=> addr == $past(addr) - (ONE << $past(size)));

endmodule

// File: rtl/dma_au_seq.sv
module dma_au_seq
  import dma_au_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          go,
  input  logic [1:0]    xmode,
  input  logic [CW-1:0] cnt_init,
  input  logic [CW-1:0] blk_len,
  input  logic          blk_side,
  output logic          busy,
  output logic          done,
  output logic          adv_src,
  output logic          adv_dst,
  output logic          rel_src,
  output logic          rel_dst
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt, ucnt;
  logic          fire, last_cnt, last_unit, empty;

  assign fire      = go && busy && !start;
  assign last_cnt  = (cnt == ONE);
  assign last_unit = (ucnt == ONE);
  assign empty     = (cnt_init == '0) || (xmode == XM_BLOCK && blk_len == '0);

  always_comb begin
    adv_src = 1'b0;
    adv_dst = 1'b0;
    rel_src = 1'b0;
    rel_dst = 1'b0;
    if (fire) begin
      unique case (xmode)
        XM_NORMAL: begin
          adv_src = 1'b1;
          adv_dst = 1'b1;
        end
        XM_REPEAT: begin
          rel_src = last_cnt;
          rel_dst = last_cnt;
          adv_src = !last_cnt;
          adv_dst = !last_cnt;
        end
        XM_BLOCK: begin
          rel_src = last_unit && !blk_side;
          rel_dst = last_unit && blk_side;
          adv_src = !(last_unit && !blk_side);
          adv_dst = !(last_unit && blk_side);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      ucnt <= '0;
    end else if (start) begin
      cnt  <= cnt_init;
      ucnt <= blk_len;
      busy <= !empty;
      done <= empty;
    end else if (fire) begin
      unique case (xmode)
        XM_NORMAL: begin
          cnt <= cnt - ONE;
          if (last_cnt) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        XM_REPEAT: cnt <= last_cnt ? cnt_init : (cnt - ONE);
        XM_BLOCK: begin
          if (last_unit) begin
            ucnt <= blk_len;
            cnt  <= cnt - ONE;
            if (last_cnt) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            ucnt <= ucnt - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: done holds until the next start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  // R10: a side is never both restored and stepped
  p_side_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adv_src, rel_src}) && $onehot0({adv_dst, rel_dst}));

  // R9: repeat mode never finishes
  p_repeat_no_done_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && xmode == XM_REPEAT) |=> !done);

endmodule

// File: rtl/dma_addr_update.sv
module dma_addr_update
  import dma_au_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          start,
  input  logic          xfer_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [1:0]    size_code,
  output logic          cfg_err,
  output logic          done
);

  logic [15:0]   ctrl_q;
  logic [AW-1:0] base_src, base_dst;
  logic [CW-1:0] cnt_init, blk_len;
  logic          blk_side;
  logic          busy, adv_src, adv_dst, rel_src, rel_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      cfg_err  <= 1'b0;
      base_src <= '0;
      base_dst <= '0;
      cnt_init <= '0;
      blk_len  <= '0;
      blk_side <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_sel)
        SEL_CTRL: begin
          ctrl_q  <= {wr_data[15:8], 8'h00};
          cfg_err <= ctrl_illegal(wr_data[15:0]);
        end
        SEL_SRC: base_src <= wr_data;
        SEL_DST: base_dst <= wr_data;
        SEL_CNT: cnt_init <= wr_data[CW-1:0];
        SEL_BLK: begin
          blk_len  <= wr_data[CW-1:0];
          blk_side <= wr_data[CW];
        end
        default: ;
      endcase
    end
  end

  assign size_code = ctrl_q[9:8];

  dma_au_seq #(.CW(CW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .go       (xfer_done && !cfg_err),
    .xmode    (ctrl_q[11:10]),
    .cnt_init (cnt_init),
    .blk_len  (blk_len),
    .blk_side (blk_side),
    .busy     (busy),
    .done     (done),
    .adv_src  (adv_src),
    .adv_dst  (adv_dst),
    .rel_src  (rel_src),
    .rel_dst  (rel_dst)
  );

  dma_au_chan #(.AW(AW)) u_src (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .reload (rel_src),
    .adv    (adv_src),
    .pol    (ctrl_q[15:14]),
    .size   (ctrl_q[9:8]),
    .base   (base_src),
    .addr   (src_addr)
  );

  dma_au_chan #(.AW(AW)) u_dst (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .reload (rel_dst),
    .adv    (adv_dst),
    .pol    (ctrl_q[13:12]),
    .size   (ctrl_q[9:8]),
    .base   (base_dst),
    .addr   (dst_addr)
  );

  // R7: an illegal control word raises the error flag
  p_bad_ctrl_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CTRL && ctrl_illegal(wr_data[15:0])) |=> cfg_err);

  // R7: addresses frozen while the error flag is up
  p_err_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !start) |=> ($stable(src_addr) && $stable(dst_addr)));

  // R12: idle strobes move nothing
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr)));

endmodule

// File: tb/tb_dma_addr_update.sv
`timescale 1ns/1ps
module tb_dma_addr_update;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        start = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic [1:0]  size_code;
  logic        cfg_err, done;

  always #2.5 clk = ~clk;

  dma_addr_update dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .xfer_done(xfer_done), .src_addr(src_addr),
    .dst_addr(dst_addr), .size_code(size_code), .cfg_err(cfg_err), .done(done)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 1'b0;
  string req = "R1";

  // Behavioural reference model
  logic [31:0] m_src = 0, m_dst = 0, m_bs = 0, m_bd = 0;
  logic [15:0] m_ctrl = 0, m_ci = 0, m_bl = 0, m_cnt = 0, m_uc = 0;
  logic        m_side = 0, m_busy = 0, m_done = 0, m_err = 0;

  function automatic logic [31:0] stepped(input logic [31:0] a, input logic [1:0] pol,
                                          input logic [1:0] sz);
    logic [31:0] s;
    s = 32'd1 << sz;
    if (pol == 2'b10) return a + s;
    if (pol == 2'b11) return a - s;
    return a;
  endfunction

  always @(posedge clk) begin
    logic [1:0] sp, dp, sz, md;
    sp = m_ctrl[15:14]; dp = m_ctrl[13:12]; sz = m_ctrl[9:8]; md = m_ctrl[11:10];
    if (rst) begin
      m_src = 0; m_dst = 0; m_bs = 0; m_bd = 0; m_ctrl = 0; m_ci = 0; m_bl = 0;
      m_cnt = 0; m_uc = 0; m_side = 0; m_busy = 0; m_done = 0; m_err = 0;
    end else begin
      if (start) begin
        m_src = m_bs; m_dst = m_bd; m_cnt = m_ci; m_uc = m_bl;
        if (m_ci == 0 || (md == 2'b10 && m_bl == 0)) begin
          m_busy = 0; m_done = 1;
        end else begin
          m_busy = 1; m_done = 0;
        end
      end else if (xfer_done && m_busy && !m_err) begin
        if (md == 2'b00) begin
          m_src = stepped(m_src, sp, sz); m_dst = stepped(m_dst, dp, sz);
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
        end else if (md == 2'b01) begin
          if (m_cnt == 1) begin
            m_src = m_bs; m_dst = m_bd; m_cnt = m_ci;
          end else begin
            m_src = stepped(m_src, sp, sz); m_dst = stepped(m_dst, dp, sz);
            m_cnt = m_cnt - 1;
          end
        end else if (md == 2'b10) begin
          if (m_uc == 1) begin
            m_uc = m_bl;
            if (m_side) begin m_dst = m_bd; m_src = stepped(m_src, sp, sz); end
            else        begin m_src = m_bs; m_dst = stepped(m_dst, dp, sz); end
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
          end else begin
            m_src = stepped(m_src, sp, sz); m_dst = stepped(m_dst, dp, sz);
            m_uc = m_uc - 1;
          end
        end
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: begin
            m_ctrl = {wr_data[15:8], 8'h00};
            m_err  = (wr_data[11:10] == 2'b11) || (wr_data[9:8] == 2'b11);
          end
          3'd1: m_bs = wr_data;
          3'd2: m_bd = wr_data;
          3'd3: m_ci = wr_data[15:0];
          3'd4: begin m_bl = wr_data[15:0]; m_side = wr_data[16]; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("src_addr", src_addr, m_src);
      check("dst_addr", dst_addr, m_dst);
      check("size_code", {30'd0, size_code}, {30'd0, m_ctrl[9:8]});
      check("cfg_err", {31'd0, cfg_err}, {31'd0, m_err});
      check("done", {31'd0, done}, {31'd0, m_done});
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic xfers(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xfer_done = 1'b1;
    end
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic setup(input logic [31:0] bs, input logic [31:0] bd,
                       input logic [15:0] c, input logic [15:0] ctrl);
    wr(3'd1, bs); wr(3'd2, bd); wr(3'd3, {16'd0, c}); wr(3'd0, {16'd0, ctrl});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    req = "R1"; repeat (2) @(negedge clk);
    req = "R12"; xfers(3);
    req = "R2"; wr(3'd1, 32'h0000_1000); wr(3'd2, 32'h0000_2000); wr(3'd3, 32'd3);
    wr(3'd0, 32'h8000); go();
    req = "R3"; xfers(2);
    req = "R8"; xfers(3);
    req = "R4"; setup(32'h10, 32'h400, 16'd4, 16'h3100); go();
    req = "R5"; xfers(3);
    req = "R6"; setup(32'hFFFF_FFF8, 32'h2, 16'd5, 16'hB200); go(); xfers(4);
    req = "R7"; setup(32'h100, 32'h200, 16'd6, 16'h8300); go(); xfers(2);
    wr(3'd0, 32'hAC00); xfers(2);
    wr(3'd0, 32'h8000); xfers(2);
    req = "R9"; setup(32'h50, 32'h90, 16'd2, 16'hA400); go(); xfers(5);
    req = "R10"; wr(3'd4, 32'h0001_0003); setup(32'h300, 32'h700, 16'd2, 16'hA900);
    go(); xfers(8);
    wr(3'd4, 32'h0000_0002); wr(3'd0, 32'hE800); go(); xfers(6);
    req = "R11"; wr(3'd3, 32'd0); go(); xfers(3);
    wr(3'd3, 32'd2); wr(3'd4, 32'd0); go(); xfers(3);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule